// File: doc/BRIEF.md
# DMA Channel Control and Completion Interrupt Coalescer

This block is the per-channel control and status front end of a descriptor-driven DMA channel. A 32-bit register port reaches four registers in a 0x30-byte channel window: control, status, current descriptor pointer and tail descriptor pointer. The block holds the run/stop and soft-reset state and keeps the halted and idle flags. The data mover that fetches descriptors and moves data sits outside this block. It reports to the block through a one-cycle packet-complete pulse and a one-cycle reached-tail pulse.

Completion interrupts are coalesced in two ways. A packet counter is loaded from a threshold field in the control register. Each completion decrements it, and when it reaches zero it raises the completion interrupt and reloads. A delay timer restarts on every completion and counts down on prescaled ticks. If it runs out before the threshold is met, it raises the delay interrupt and reloads the packet counter. Software reads both live counters in the upper half of the status register. Interrupt bits are write-one-to-clear. A single level output is high while any pending interrupt bit has its enable set.

Register offsets: control 0x00, status 0x04, current descriptor 0x08, tail descriptor 0x10. Other offsets in the window read as zero and ignore writes.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, control reads 0x00010002 (threshold 1 in bits 23:16), status reads 0x00010001 (halted in bit 0, packet count 1 in bits 23:16), and irq_o is low.
- R2: Control bit 1 (tail-pointer mode) always reads 1 and control bit 2 (soft reset) always reads 0. All other control bits read back as last written.
- R3: A control write with bit 0 (run) set clears status bit 0 (halted) and bit 1 (idle), unless a soft reset is pending. A soft reset stays pending from its write until the next read of control.
- R4: A control write with bit 2 set returns the channel to its reset state: control reads 0x00010002, status reads 0x00010001, packet count 1, timer 0, all interrupt bits clear.
- R5: A write to the tail descriptor register clears the idle flag. A reached-tail pulse sets it. Both descriptor registers read back the value written.
- R6: Each packet-complete pulse decrements the packet count (status bits 23:16). When the count leaves 1, status bit 12 is set and the count reloads from control bits 23:16.
- R7: Every control write reloads the packet count from control bits 23:16.
- R8: A packet-complete pulse loads the delay timer (status bits 31:24) from control bits 31:24 when that field is nonzero. The timer drops by one every TICK_DIV tick pulses. The step to zero sets status bit 13 and reloads the packet count, exactly delay x TICK_DIV ticks after the last completion.
- R9: Writing 1 to any of status bits 14:12 clears that bit. Bits written 0 keep their value, and status writes change nothing else.
- R10: irq_o is high exactly when some bit in status 14:12 is set together with the same bit of control.
- R11: With control bits 31:24 at zero, completions do not start the timer and ticks never raise status bit 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte offset inside the channel window |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| pkt_done_i | input | 1 | One-cycle packet-complete pulse from the data mover |
| tail_hit_i | input | 1 | One-cycle pulse: the mover finished the tail descriptor |
| tick_i | input | 1 | Delay timer time base pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is the soft-reset pending window. A run request sent in that window must be refused, and only a read of control closes the window. The stimulus writes soft reset, then run, before any control read, and shows halted still set. After one control read, the same run write clears it. The delay timer expiry is the other narrow case. The stimulus sweeps several delay values and checks the timer field after every single tick, so an expiry one tick early or late is caught. It also restarts the timer mid-count with a second completion to show the countdown starts over from the full delay.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;
  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_STAT = 'h04;
  localparam int unsigned OFS_CUR  = 'h08;
  localparam int unsigned OFS_TAIL = 'h10;

  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_TPM  = 1;
  localparam int unsigned CB_SRST = 2;
  localparam int unsigned SB_HALT = 0;
  localparam int unsigned SB_IDLE = 1;
  localparam int unsigned IRQ_LO  = 12;
  localparam int unsigned IRQ_W   = 3;
  localparam int unsigned THR_LO  = 16;
  localparam int unsigned DLY_LO  = 24;
  localparam int unsigned FLD_W   = 8;

  localparam logic [31:0] CTRL_RST = 32'h0001_0000;
endpackage

// File: rtl/dma_cc_coalesce.sv
module dma_cc_coalesce #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned TMR_W    = 8,
  parameter int unsigned TICK_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [TMR_W-1:0] delay_i,
  input  logic             pkt_done_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [TMR_W-1:0] tmr_o,
  output logic             ioc_o,
  output logic             dly_o
);
  localparam int unsigned PS_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [TMR_W-1:0] tmr_q;
  logic [PS_W-1:0]  ps_q;
  logic             restart, run, step, expire;

  assign restart = pkt_done_i && (delay_i != '0);
  assign run     = (tmr_q != '0);
  assign step    = run && tick_i && (ps_q == PS_LAST);
  assign expire  = step && (tmr_q == TMR_W'(1)) && !restart;
  assign ioc_o   = pkt_done_i && !reload_i && !expire && !clear_i && (cnt_q == CNT_W'(1));
  assign dly_o   = expire && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      ps_q  <= '0;
    end else if (clear_i) begin
      tmr_q <= '0;
      ps_q  <= '0;
    end else if (restart) begin
      tmr_q <= delay_i;
      ps_q  <= '0;
    end else if (run && tick_i) begin
      if (ps_q == PS_LAST) begin
        ps_q  <= '0;
        tmr_q <= tmr_q - TMR_W'(1);
      end else begin
        ps_q <= ps_q + PS_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= CNT_W'(1);
    else if (clear_i)   cnt_q <= CNT_W'(1);
    else if (reload_i)  cnt_q <= thresh_i;
    else if (expire)    cnt_q <= thresh_i;
    else if (pkt_done_i) begin
      if (cnt_q == CNT_W'(1)) cnt_q <= thresh_i;
      else                    cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign tmr_o = tmr_q;

  AST_IOC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ioc_o |=> cnt_q == $past(thresh_i)); // R6
  AST_TMR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart && !clear_i |=> tmr_q == $past(delay_i)); // R8
  AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !pkt_done_i && !clear_i |=> $stable(tmr_q)); // R8
  AST_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_q == '0) && !restart |=> tmr_q == '0); // R11
endmodule

// File: rtl/dma_cc_regs.sv
module dma_cc_regs
  import dma_cc_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              ioc_set_i,
  input  logic              dly_set_i,
  input  logic              tail_hit_i,
  output logic [31:0]       ctrl_o,
  output logic              halted_o,
  output logic              idle_o,
  output logic [IRQ_W-1:0]  irq_o,
  output logic [31:0]       cur_o,
  output logic [31:0]       tail_o,
  output logic              clear_o,
  output logic              reload_o
);
  logic [31:0]      ctrl_q, cur_q, tail_q;
  logic             halted_q, idle_q, pend_q;
  logic [IRQ_W-1:0] irq_q;
  logic             ctrl_we, stat_we, cur_we, tail_we, ctrl_re, srst_we, run_ok;

  assign ctrl_we = we_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign stat_we = we_i && (addr_i == ADDR_W'(OFS_STAT));
  assign cur_we  = we_i && (addr_i == ADDR_W'(OFS_CUR));
  assign tail_we = we_i && (addr_i == ADDR_W'(OFS_TAIL));
  assign ctrl_re = re_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign srst_we = ctrl_we && wdata_i[CB_SRST];
  assign run_ok  = ctrl_we && !srst_we && wdata_i[CB_RUN] && !pend_q;

  assign clear_o  = srst_we;
  assign reload_o = ctrl_we && !srst_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      pend_q <= 1'b0;
    end else if (srst_we) begin
      ctrl_q <= CTRL_RST;
      pend_q <= 1'b1;
    end else begin
      if (ctrl_we) begin
        ctrl_q          <= wdata_i;
        ctrl_q[CB_TPM]  <= 1'b0;
        ctrl_q[CB_SRST] <= 1'b0;
      end
      if (ctrl_re) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q <= 1'b1;
      idle_q   <= 1'b0;
      irq_q    <= '0;
    end else if (srst_we) begin
      halted_q <= 1'b1;
      idle_q   <= 1'b0;
      irq_q    <= '0;
    end else begin
      if (run_ok)                  halted_q <= 1'b0;
      if (run_ok || tail_we)       idle_q   <= 1'b0;
      else if (tail_hit_i)         idle_q   <= 1'b1;
      irq_q <= (irq_q & ~(stat_we ? wdata_i[IRQ_LO +: IRQ_W] : '0))
             | {1'b0, dly_set_i, ioc_set_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      tail_q <= '0;
    end else begin
      if (cur_we)  cur_q  <= wdata_i;
      if (tail_we) tail_q <= wdata_i;
    end
  end

  always_comb begin
    ctrl_o          = ctrl_q;
    ctrl_o[CB_TPM]  = 1'b1;
    ctrl_o[CB_SRST] = 1'b0;
  end
  assign halted_o = halted_q;
  assign idle_o   = idle_q;
  assign irq_o    = irq_q;
  assign cur_o    = cur_q;
  assign tail_o   = tail_q;

  AST_TAIL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_we |=> !idle_q); // R5
  AST_SRST_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_we |=> halted_q && (irq_q == '0)); // R4
  AST_PEND_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we && pend_q && !srst_we |=> halted_q == $past(halted_q)); // R3
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we && wdata_i[IRQ_LO] && !ioc_set_i && !srst_we |=> !irq_q[0]); // R9
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_cc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned TMR_W    = 8,
  parameter int unsigned TICK_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              pkt_done_i,
  input  logic              tail_hit_i,
  input  logic              tick_i,
  output logic              irq_o
);
  localparam int unsigned CNT_W = FLD_W;

  logic [31:0]      ctrl, cur, tail;
  logic             halted, idle, clear, reload, ioc_set, dly_set;
  logic [IRQ_W-1:0] irq_pend;
  logic [CNT_W-1:0] cnt;
  logic [TMR_W-1:0] tmr;
  logic [31:0]      stat;

  dma_cc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .re_i       (reg_re_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .ioc_set_i  (ioc_set),
    .dly_set_i  (dly_set),
    .tail_hit_i (tail_hit_i),
    .ctrl_o     (ctrl),
    .halted_o   (halted),
    .idle_o     (idle),
    .irq_o      (irq_pend),
    .cur_o      (cur),
    .tail_o     (tail),
    .clear_o    (clear),
    .reload_o   (reload)
  );

  dma_cc_coalesce #(.CNT_W(CNT_W), .TMR_W(TMR_W), .TICK_DIV(TICK_DIV)) u_coal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .reload_i   (reload),
    .thresh_i   (reg_wdata_i[THR_LO +: CNT_W] & {CNT_W{reload}} | ctrl[THR_LO +: CNT_W] & {CNT_W{!reload}}),
    .delay_i    (TMR_W'(ctrl[DLY_LO +: FLD_W])),
    .pkt_done_i (pkt_done_i),
    .tick_i     (tick_i),
    .cnt_o      (cnt),
    .tmr_o      (tmr),
    .ioc_o      (ioc_set),
    .dly_o      (dly_set)
  );

  always_comb begin
    stat                      = '0;
    stat[SB_HALT]             = halted;
    stat[SB_IDLE]             = idle;
    stat[IRQ_LO +: IRQ_W]     = irq_pend;
    stat[THR_LO +: FLD_W]     = cnt;
    stat[DLY_LO +: FLD_W]     = FLD_W'(tmr);
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_W'(OFS_CTRL): reg_rdata_o = ctrl;
      ADDR_W'(OFS_STAT): reg_rdata_o = stat;
      ADDR_W'(OFS_CUR):  reg_rdata_o = cur;
      ADDR_W'(OFS_TAIL): reg_rdata_o = tail;
      default:           reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(irq_pend & ctrl[IRQ_LO +: IRQ_W]);

  AST_TPM_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl[CB_TPM] && !ctrl[CB_SRST]); // R2
  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear |=> !irq_o); // R10
endmodule

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
  localparam int CLK_P = 10;
  localparam int TD    = 2;
  localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h04, A_CUR = 6'h08, A_TAIL = 6'h10;

  logic clk = 0, rst_n = 0;
  logic we = 0, re = 0, pkt = 0, hit = 0, tick = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_chan_ctrl #(.ADDR_W(6), .TMR_W(8), .TICK_DIV(TD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pkt_done_i(pkt), .tail_hit_i(hit),
    .tick_i(tick), .irq_o(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); re = 1; addr = a; #1 v = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic pulse_pkt();  @(negedge clk); pkt = 1;  @(negedge clk); pkt = 0;  endtask
  task automatic pulse_tick(); @(negedge clk); tick = 1; @(negedge clk); tick = 0; endtask
  task automatic pulse_hit();  @(negedge clk); hit = 1;  @(negedge clk); hit = 0;  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cexp, texp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0001_0002);
    rd(A_STAT, v); chk("R1 stat", v, 32'h0001_0001);
    chk("R1 irq", {31'b0, irq}, 0);
    // R2
    wr(A_CTRL, 32'h0000_5000); rd(A_CTRL, v); chk("R2 ctrl bits", v, 32'h0000_5002);
    // R3 run clears halted
    wr(A_CTRL, 32'h0001_0001); rd(A_STAT, v); chk("R3 run", v, 32'h0001_0000);
    // R5 idle and descriptors
    pulse_hit(); rd(A_STAT, v); chk("R5 idle set", v, 32'h0001_0002);
    wr(A_TAIL, 32'hCAFE_0100); rd(A_STAT, v); chk("R5 tail clr idle", v, 32'h0001_0000);
    rd(A_TAIL, v); chk("R5 tail rb", v, 32'hCAFE_0100);
    wr(A_CUR, 32'h1234_5678); rd(A_CUR, v); chk("R5 cur rb", v, 32'h1234_5678);
    rd(6'h20, v); chk("R5 unused ofs", v, 0);
    // R4 soft reset and R3 pending window
    wr(A_CTRL, 32'h0003_0001); pulse_pkt(); pulse_pkt(); pulse_pkt();
    rd(A_STAT, v); chk("R6 pre-srst ioc", v[12], 1);
    wr(A_CTRL, 32'h0503_0005);
    rd(A_STAT, v); chk("R4 stat", v, 32'h0001_0001);
    wr(A_CTRL, 32'h0001_0001);
    rd(A_STAT, v); chk("R3 pending blocks run", v, 32'h0001_0001);
    rd(A_CTRL, v); chk("R2 srst reads 0", v, 32'h0001_0003);
    wr(A_CTRL, 32'h0001_0001);
    rd(A_STAT, v); chk("R3 run after read", v, 32'h0001_0000);
    // R6 R7 threshold sweep
    for (int thr = 1; thr <= 4; thr++) begin
      wr(A_CTRL, (thr << 16) | 1); wr(A_STAT, 32'h0000_7000);
      rd(A_STAT, v); chk("R7 reload", v[23:16], thr);
      for (int k = 1; k <= 2 * thr + 1; k++) begin
        pulse_pkt(); rd(A_STAT, v);
        cexp = (k % thr == 0) ? thr : thr - (k % thr);
        chk("R6 count", v[23:16], cexp);
        chk("R6 ioc", v[12], (k >= thr) ? 1 : 0);
      end
    end
    // R7 reload mid count
    wr(A_CTRL, 32'h0009_0001); pulse_pkt(); pulse_pkt();
    wr(A_CTRL, 32'h0006_0001); rd(A_STAT, v); chk("R7 mid reload", v[23:16], 6);
    // R10 R9
    wr(A_STAT, 32'h0000_7000); wr(A_CTRL, 32'h0001_0001); pulse_pkt();
    chk("R10 masked", {31'b0, irq}, 0);
    wr(A_CTRL, 32'h0001_1001); chk("R10 enabled", {31'b0, irq}, 1);
    wr(A_STAT, 32'h0000_0000); rd(A_STAT, v); chk("R9 zero write keeps", v[12], 1);
    wr(A_STAT, 32'h0000_2000); rd(A_STAT, v); chk("R9 other bit keeps", v[12], 1);
    wr(A_STAT, 32'h0000_1000); rd(A_STAT, v); chk("R9 w1c", v[12], 0);
    chk("R10 cleared", {31'b0, irq}, 0);
    // R8 delay sweep
    for (int d = 1; d <= 4; d++) begin
      wr(A_CTRL, (d << 24) | (200 << 16) | 32'h2001); wr(A_STAT, 32'h0000_7000);
      pulse_pkt(); rd(A_STAT, v); chk("R8 start", v[31:24], d);
      for (int t = 1; t < d * TD; t++) begin
        pulse_tick(); rd(A_STAT, v);
        texp = d - t / TD;
        chk("R8 count", v[31:24], texp);
        chk("R8 early", v[13], 0);
      end
      pulse_tick(); rd(A_STAT, v);
      chk("R8 zero", v[31:24], 0);
      chk("R8 dly", v[13], 1);
      chk("R8 cnt reload", v[23:16], 200);
      chk("R10 dly irq", {31'b0, irq}, 1);
    end
    // R8 restart mid count
    wr(A_CTRL, 32'h0314_0001); wr(A_STAT, 32'h0000_7000);
    pulse_pkt(); repeat (3) pulse_tick(); rd(A_STAT, v); chk("R8 partial", v[31:24], 2);
    pulse_pkt(); rd(A_STAT, v); chk("R8 restart", v[31:24], 3);
    repeat (5) pulse_tick(); rd(A_STAT, v);
    chk("R8 after restart", v[31:24], 1); chk("R8 no early dly", v[13], 0);
    pulse_tick(); rd(A_STAT, v); chk("R8 restart dly", v[13], 1);
    // R11 zero delay
    wr(A_CTRL, 32'h0014_0001); wr(A_STAT, 32'h0000_7000);
    pulse_pkt(); repeat (6) pulse_tick(); rd(A_STAT, v);
    chk("R11 timer idle", v[31:24], 0); chk("R11 no dly", v[13], 0);
    // R4 clears pending irq
    wr(A_CTRL, 32'h0001_1001); pulse_pkt(); chk("R10 pre", {31'b0, irq}, 1);
    wr(A_CTRL, 32'h0000_0004);
    rd(A_STAT, v); chk("R4 stat clr", v, 32'h0001_0001);
    rd(A_CTRL, v); chk("R4 ctrl", v, 32'h0001_0002);
    chk("R4 irq low", {31'b0, irq}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule